// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset pair into a 20-bit physical memory address. The 16-bit effective offset comes from one of several operand forms: a plain 16-bit direct value, a base register (BX or BP), an index register (SI or DI), or both registers together. Each of these forms may add an 8-bit sign-extended displacement or a 16-bit displacement. Instruction fetches use IP as the offset, stack accesses use SP, and string destinations use DI.

The segment register comes from the access kind and the base register in use. An override input can replace the default for data operands. The final address is the segment value shifted left by four bits plus the offset. The result is registered and qualified by a valid flag one clock after the request strobe. Instruction decoding and bus cycles are handled elsewhere.

Top module: `seg_addr_gen`

## Requirements
- R1: One clock after a cycle with `req_i` high, `valid_o` is 1 and `paddr_o` = (segment value * 16 + offset) mod 2^20 (segment 2000h, offset 1000h gives 21000h).
- R2: One clock after a cycle with `req_i` low, `valid_o` is 0 and `paddr_o` and `seg_sel_o` keep their previous values.
- R3: `kind_i` = 1 (instruction fetch) selects CS with IP as offset. Mode and override inputs are ignored.
- R4: `kind_i` = 2 (stack) selects SS with SP as offset. Mode and override inputs are ignored.
- R5: `kind_i` = 3 (string destination) selects ES with DI as offset. Any override is ignored.
- R6: For `kind_i` = 0 (data) without override, the segment is SS when the form has a base (`form_i` bit 0 set) and `base_bp_i` = 1, and DS otherwise. `seg_sel_o` codes are 0 ES, 1 CS, 2 SS, 3 DS.
- R7: For data accesses with `ovr_en_i` = 1, the segment coded by `ovr_seg_i` (same codes as R6) replaces the default.
- R8: `form_i` = 0 (direct) uses `disp_i` as the offset whatever `disp_sz_i` holds.
- R9: `form_i` = 1 adds base (BX, or BP when `base_bp_i`), 2 adds index (SI, or DI when `index_di_i`), and 3 adds both, plus the displacement.
- R10: `disp_sz_i` = 1 adds `disp_i[7:0]` sign-extended to 16 bits, 2 adds all of `disp_i`, and 0 or 3 adds nothing.
- R11: The offset sum wraps modulo 2^16 before the segment is added.
- R12: During reset `valid_o`, `paddr_o` and `seg_sel_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| kind_i | input | 2 | Access kind: 0 data, 1 fetch, 2 stack, 3 string destination |
| form_i | input | 2 | Offset form: 0 direct, 1 base, 2 index, 3 base+index |
| disp_sz_i | input | 2 | Displacement: 0 none, 1 8-bit signed, 2 16-bit, 3 none |
| base_bp_i | input | 1 | Base register is BP (else BX) |
| index_di_i | input | 1 | Index register is DI (else SI) |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| sp_i | input | 16 | SP value |
| ip_i | input | 16 | IP value |
| disp_i | input | 16 | Displacement or direct offset |
| cs_i | input | 16 | CS value |
| ds_i | input | 16 | DS value |
| ss_i | input | 16 | SS value |
| es_i | input | 16 | ES value |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_seg_i | input | 2 | Override segment code |
| paddr_o | output | 20 | Physical address |
| seg_sel_o | output | 2 | Chosen segment code |
| valid_o | output | 1 | Address valid |

## Verification
The hardest cases to reach from the ports are the two wrap-arounds. One is an offset sum that carries out of 16 bits. The other is a segment-plus-offset sum that carries out of 20 bits. A random mix of register values rarely produces either one, so directed cases load all-ones registers and segments to force both carries. A negative 8-bit displacement is included in the same way. Directed requests also set the override while a string destination is in progress, to show that ES still wins. A long random run then compares every cycle, including idle cycles, against a behavioural model.

// File: rtl/seg_agen_pkg.sv
package seg_agen_pkg;
  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_code_e;

  typedef enum logic [1:0] {
    ACC_DATA  = 2'd0,
    ACC_FETCH = 2'd1,
    ACC_STACK = 2'd2,
    ACC_STRD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FORM_DIRECT = 2'd0,
    FORM_BASE   = 2'd1,
    FORM_INDEX  = 2'd2,
    FORM_BOTH   = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_8    = 2'd1,
    DISP_16   = 2'd2,
    DISP_RSV  = 2'd3
  } disp_sz_e;

  localparam int unsigned NUM_SEGS = 4;
endpackage

// File: rtl/seg_offset_calc.sv
module seg_offset_calc
  import seg_agen_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DISP8_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_kind_e         kind_i,
  input  form_e             form_i,
  input  disp_sz_e          disp_sz_i,
  input  logic              base_bp_i,
  input  logic              index_di_i,
  input  logic [WORD_W-1:0] bx_i,
  input  logic [WORD_W-1:0] bp_i,
  input  logic [WORD_W-1:0] si_i,
  input  logic [WORD_W-1:0] di_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] disp_i,
  output logic [WORD_W-1:0] off_o,
  output logic              bp_based_o
);
  localparam int unsigned EXT_W = WORD_W - DISP8_W;

  logic              use_base, use_index;
  logic [WORD_W-1:0] base_val, index_val, disp_val, mode_off;

  assign use_base  = form_i[0];
  assign use_index = form_i[1];
  assign base_val  = use_base  ? (base_bp_i  ? bp_i : bx_i) : '0;
  assign index_val = use_index ? (index_di_i ? di_i : si_i) : '0;

  always_comb begin
    unique case (disp_sz_i)
      DISP_8:  disp_val = {{EXT_W{disp_i[DISP8_W-1]}}, disp_i[DISP8_W-1:0]};
      DISP_16: disp_val = disp_i;
      default: disp_val = '0;
    endcase
  end

  // sum truncates to WORD_W: wraps modulo 2^WORD_W
  assign mode_off = (form_i == FORM_DIRECT) ? disp_i
                                            : base_val + index_val + disp_val;

  always_comb begin
    unique case (kind_i)
      ACC_FETCH: off_o = ip_i;
      ACC_STACK: off_o = sp_i;
      ACC_STRD:  off_o = di_i;
      default:   off_o = mode_off;
    endcase
  end

  assign bp_based_o = (kind_i == ACC_DATA) && use_base && base_bp_i;

  p_direct_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == ACC_DATA && form_i == FORM_DIRECT) |-> off_o == disp_i);
  p_fetch_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == ACC_FETCH) |-> off_o == ip_i);
  p_stack_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == ACC_STACK) |-> off_o == sp_i);
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_agen_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_kind_e         kind_i,
  input  logic              bp_based_i,
  input  logic              ovr_en_i,
  input  seg_code_e         ovr_seg_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ds_i,
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] es_i,
  output seg_code_e         seg_o,
  output logic [WORD_W-1:0] seg_val_o
);
  logic [WORD_W-1:0]   seg_tab [NUM_SEGS];
  logic [NUM_SEGS-1:0] seg_oh;
  seg_code_e           dflt_seg;

  assign seg_tab[SEG_ES] = es_i;
  assign seg_tab[SEG_CS] = cs_i;
  assign seg_tab[SEG_SS] = ss_i;
  assign seg_tab[SEG_DS] = ds_i;

  always_comb begin
    unique case (kind_i)
      ACC_FETCH: seg_o = SEG_CS;
      ACC_STACK: seg_o = SEG_SS;
      ACC_STRD:  seg_o = SEG_ES;  // no override for string destination
      default: begin
        dflt_seg = bp_based_i ? SEG_SS : SEG_DS;
        seg_o    = ovr_en_i ? ovr_seg_i : dflt_seg;
      end
    endcase
    if (kind_i != ACC_DATA) dflt_seg = SEG_DS;
  end

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_oh
    assign seg_oh[g] = (seg_o == seg_code_e'(g));
  end

  always_comb begin
    seg_val_o = '0;
    for (int i = 0; i < NUM_SEGS; i++)
      seg_val_o |= seg_oh[i] ? seg_tab[i] : '0;
  end

  p_seg_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(seg_oh));
  p_strd_es_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == ACC_STRD) |-> seg_val_o == es_i);
  p_fetch_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == ACC_FETCH) |-> seg_val_o == cs_i);
  p_ovr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == ACC_DATA && ovr_en_i) |-> seg_o == ovr_seg_i);
endmodule

// File: rtl/seg_phys_reg.sv
module seg_phys_reg
  import seg_agen_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SEG_SHIFT = 4,
  localparam int unsigned PADDR_W  = WORD_W + SEG_SHIFT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  seg_code_e          seg_i,
  input  logic [WORD_W-1:0]  seg_val_i,
  input  logic [WORD_W-1:0]  off_i,
  output logic [PADDR_W-1:0] paddr_o,
  output seg_code_e          seg_o,
  output logic               valid_o
);
  logic [PADDR_W-1:0] sum;

  // carry out of PADDR_W is dropped: wraps modulo 2^PADDR_W
  assign sum = {seg_val_i, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_o <= '0;
      seg_o   <= SEG_ES;
      valid_o <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        paddr_o <= sum;
        seg_o   <= seg_i;
      end
    end
  end

  p_valid_lag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  p_low_nibble_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> paddr_o[SEG_SHIFT-1:0] == $past(off_i[SEG_SHIFT-1:0]));
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o && $stable(paddr_o) && $stable(seg_o));
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_agen_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SEG_SHIFT = 4,
  localparam int unsigned PADDR_W  = WORD_W + SEG_SHIFT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [1:0]         kind_i,
  input  logic [1:0]         form_i,
  input  logic [1:0]         disp_sz_i,
  input  logic               base_bp_i,
  input  logic               index_di_i,
  input  logic [WORD_W-1:0]  bx_i,
  input  logic [WORD_W-1:0]  bp_i,
  input  logic [WORD_W-1:0]  si_i,
  input  logic [WORD_W-1:0]  di_i,
  input  logic [WORD_W-1:0]  sp_i,
  input  logic [WORD_W-1:0]  ip_i,
  input  logic [WORD_W-1:0]  disp_i,
  input  logic [WORD_W-1:0]  cs_i,
  input  logic [WORD_W-1:0]  ds_i,
  input  logic [WORD_W-1:0]  ss_i,
  input  logic [WORD_W-1:0]  es_i,
  input  logic               ovr_en_i,
  input  logic [1:0]         ovr_seg_i,
  output logic [PADDR_W-1:0] paddr_o,
  output logic [1:0]         seg_sel_o,
  output logic               valid_o
);
  acc_kind_e         kind;
  logic [WORD_W-1:0] off, seg_val;
  logic              bp_based;
  seg_code_e         seg_now, seg_q;

  assign kind = acc_kind_e'(kind_i);

  seg_offset_calc #(.WORD_W(WORD_W)) u_off (
    .clk_i, .rst_ni,
    .kind_i     (kind),
    .form_i     (form_e'(form_i)),
    .disp_sz_i  (disp_sz_e'(disp_sz_i)),
    .base_bp_i, .index_di_i,
    .bx_i, .bp_i, .si_i, .di_i, .sp_i, .ip_i, .disp_i,
    .off_o      (off),
    .bp_based_o (bp_based)
  );

  seg_select #(.WORD_W(WORD_W)) u_sel (
    .clk_i, .rst_ni,
    .kind_i     (kind),
    .bp_based_i (bp_based),
    .ovr_en_i,
    .ovr_seg_i  (seg_code_e'(ovr_seg_i)),
    .cs_i, .ds_i, .ss_i, .es_i,
    .seg_o      (seg_now),
    .seg_val_o  (seg_val)
  );

  seg_phys_reg #(.WORD_W(WORD_W), .SEG_SHIFT(SEG_SHIFT)) u_reg (
    .clk_i, .rst_ni, .req_i,
    .seg_i     (seg_now),
    .seg_val_i (seg_val),
    .off_i     (off),
    .paddr_o,
    .seg_o     (seg_q),
    .valid_o
  );

  assign seg_sel_o = seg_q;

  p_strd_seg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i == 2'd3) |=> seg_sel_o == 2'd0);
endmodule

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic req = 0, base_bp = 0, index_di = 0, ovr_en = 0;
  logic [1:0] kind = 0, form = 0, dsz = 0, ovr_seg = 0;
  logic [15:0] bx = 0, bp = 0, si = 0, di = 0, sp = 0, ip = 0, disp = 0;
  logic [15:0] cs = 0, ds = 0, ss = 0, es = 0;
  logic [19:0] paddr;
  logic [1:0] seg_sel;
  logic valid;

  int n_tests = 0, n_fail = 0, cycles = 0;
  logic [19:0] exp_pa = 0;
  logic [1:0]  exp_seg = 0;

  seg_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .form_i(form),
    .disp_sz_i(dsz), .base_bp_i(base_bp), .index_di_i(index_di),
    .bx_i(bx), .bp_i(bp), .si_i(si), .di_i(di), .sp_i(sp), .ip_i(ip),
    .disp_i(disp), .cs_i(cs), .ds_i(ds), .ss_i(ss), .es_i(es),
    .ovr_en_i(ovr_en), .ovr_seg_i(ovr_seg),
    .paddr_o(paddr), .seg_sel_o(seg_sel), .valid_o(valid)
  );

  function automatic logic [15:0] ref_off();
    int o;
    case (kind)
      2'd1: return ip;
      2'd2: return sp;
      2'd3: return di;
      default: ;
    endcase
    if (form == 2'd0) return disp;
    o = 0;
    if (form[0]) o += base_bp ? int'(bp) : int'(bx);
    if (form[1]) o += index_di ? int'(di) : int'(si);
    if (dsz == 2'd1) o += int'($signed(disp[7:0]));
    else if (dsz == 2'd2) o += int'(disp);
    return 16'(o & 32'hFFFF);
  endfunction

  function automatic logic [1:0] ref_seg();
    case (kind)
      2'd1: return 2'd1;
      2'd2: return 2'd2;
      2'd3: return 2'd0;
      default: ;
    endcase
    if (ovr_en) return ovr_seg;
    return (form[0] && base_bp) ? 2'd2 : 2'd3;
  endfunction

  function automatic logic [15:0] seg_value(logic [1:0] c);
    case (c)
      2'd0: return es;
      2'd1: return cs;
      2'd2: return ss;
      default: return ds;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // inputs were set after a negedge; compute expected, cross one posedge, compare
  task automatic step(string tag);
    logic exp_v;
    exp_v = req;
    if (req) begin
      exp_seg = ref_seg();
      exp_pa  = 20'((int'(seg_value(exp_seg)) * 16 + int'(ref_off())) & 32'hFFFFF);
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, 32'(valid), 32'(exp_v));
    check({tag, " paddr"}, 32'(paddr), 32'(exp_pa));
    check({tag, " seg"}, 32'(seg_sel), 32'(exp_seg));
  endtask

  task automatic data_req(logic [1:0] f, logic [1:0] s, logic bpx, logic dix);
    req = 1; kind = 0; form = f; dsz = s; base_bp = bpx; index_di = dix; ovr_en = 0;
  endtask

  initial begin
    #3;
    @(negedge clk);
    check("R12 reset valid", 32'(valid), 0);
    check("R12 reset paddr", 32'(paddr), 0);
    check("R12 reset seg", 32'(seg_sel), 0);
    rst_n = 1;
    @(negedge clk);

    cs = 16'h1111; ds = 16'h2000; ss = 16'h3000; es = 16'h4000;
    bx = 16'h0100; bp = 16'h0200; si = 16'h0010; di = 16'h0020;
    sp = 16'hFFFE; ip = 16'h0123;

    // R1 R8: direct DS 2000h:1000h -> 21000h
    data_req(0, 0, 0, 0); disp = 16'h1000; step("R1 R8 direct");
    check("R1 literal", 32'(paddr), 32'h21000);
    dsz = 1; disp = 16'h1080; step("R8 direct ignores size");
    req = 0; kind = 1; step("R2 idle hold");
    req = 1; kind = 1; form = 3; ovr_en = 1; ovr_seg = 2; step("R3 fetch");
    kind = 2; step("R4 stack");
    kind = 3; ovr_seg = 3; step("R5 string dst override ignored");
    check("R5 seg ES", 32'(seg_sel), 0);
    data_req(1, 0, 1, 0); step("R6 BP base SS");
    check("R6 seg SS", 32'(seg_sel), 2);
    data_req(2, 0, 1, 1); step("R6 index only DS");
    check("R6 seg DS", 32'(seg_sel), 3);
    data_req(3, 2, 0, 0); disp = 16'h0004; step("R9 BX+SI+d16");
    data_req(3, 1, 1, 1); disp = 16'h0080; step("R10 BP+DI-80h");
    data_req(1, 3, 0, 0); step("R10 reserved size");
    for (int c = 0; c < 4; c++) begin
      data_req(3, 0, 1, 0); ovr_en = 1; ovr_seg = 2'(c); step("R7 override");
    end
    bx = 16'hFFFF; si = 16'h0002; data_req(3, 0, 0, 0); step("R11 offset wrap");
    ds = 16'hFFFF; disp = 16'hFFFF; data_req(0, 0, 0, 0); step("R1 paddr wrap");
    check("R1 wrap literal", 32'(paddr), 32'h0FFEF);

    for (int i = 0; i < 3000; i++) begin
      req = $urandom_range(0, 3) != 0;
      {kind, form, dsz, ovr_seg} = 8'($urandom);
      {base_bp, index_di, ovr_en} = 3'($urandom);
      {bx, bp} = $urandom; {si, di} = $urandom; {sp, ip} = $urandom;
      {cs, ds} = $urandom; {ss, es} = $urandom; disp = 16'($urandom);
      step("R1 R9 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <= 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule